// File: doc/BRIEF.md
# Debounced Multi-Source Wake Collector

This block gathers wake-up causes in a low-power system and keeps each one in a sticky flag. The wake sources are a timer expiry pulse, a push-button pin, a serial receive line, three general-purpose pins and an alternate optical receive line. Separately, six reset-cause indications are recorded: a cold start, an external reset pin, a software reset request, a watchdog overflow, an emulator reset and a low-battery condition. Each wake source has its own enable bit. The reset-cause flags have no enable and always record. A combined wake request goes high whenever any flag is set.

Every asynchronous pin first passes through a two-flop synchronizer. It is then qualified by one of two disciplines, and both are timed by one free-running prescaler. The first is a high-level qualifier. It samples on a slow tick (2 ms by default) and declares a valid level after 32 consecutive high samples, which is 64 ms. Its state machine has three states. `LQ_IDLE` moves to `LQ_COUNT` on the first high sample. `LQ_COUNT` returns to `LQ_IDLE` on any low sample, and moves to `LQ_HELD` on the 32nd consecutive high sample. `LQ_HELD` returns to `LQ_IDLE` on a low sample. The second is a transition qualifier timed on a fast tick (1 µs by default). Its state machine has two states. `EQ_STABLE` moves to `EQ_SETTLE` when the pin differs from the accepted level. `EQ_SETTLE` falls back to `EQ_STABLE` if the pin returns to that level. If the pin instead holds the new level for two fast ticks, `EQ_SETTLE` accepts it, moves to `EQ_STABLE` and reports an event. The event is reported on either edge, or on rising edges only for the reset-cause pins.

Software reads the enables and flags through a small register port. Flags are cleared by writing ones, and a cold start also clears them.

Top module: `wkup_collector`

## Requirements
- R1: After reset, the enable register, both flag registers and `wake_o` all read 0.
- R2: A one-cycle `timer_i` pulse sets pending-flag bit 5 at the next clock edge, without debounce, but only while enable bit 5 (the timer arm bit) is 1. When the arm bit is 0 the pulse has no effect.
- R3: Button (pending bit 3), general pin B (bit 1) and, in level mode, general pin C (bit 0) set their flag only after 32 consecutive high samples taken on the slow tick. A high period shorter than that never sets the flag.
- R4: A low sample taken while a level qualifier is counting restarts its count from zero. Two high periods of fewer than 32 samples each, separated by a low period, therefore do not set the flag.
- R5: Level-qualified sources are level-sensitive. While the pin remains qualified high, a clear of that flag does not take effect. Once the pin has been sampled low, the clear works. In general, a set in the same cycle wins over a clear.
- R6: The serial receive line (pending bit 4) and general pin A (bit 2) set their flag on either a rising or a falling edge that holds for two fast ticks. A pulse shorter than one fast-tick period is ignored.
- R7: Enable-register bit 7 selects the source of pending bit 0. When it is 1, that source is the level-qualified general pin C. When it is 0, it is either edge of the optical receive line with transition debounce. The source that is not selected has no effect.
- R8: The reset-cause flags need no enable. Cold start sets cause bit 7, the reset pin sets bit 6, the software reset sets bit 5, the watchdog sets bit 4, the emulator reset sets bit 3 and low battery sets bit 2. The software reset, watchdog and low-battery inputs are one-cycle pulses with no debounce. The reset pin and emulator reset must stay high for two fast ticks, so a shorter pulse is ignored.
- R9: A wake-source event that occurs while its enable bit is 0 is lost. Setting the enable bit afterwards does not create the flag.
- R10: Writing to address 1 clears the pending bits written as 1. Writing to address 2 clears the cause bits written as 1. Bits written as 0 are unchanged.
- R11: A `cold_i` pulse sets cause bit 7 and clears every other flag in both registers, except flags that are set in that same cycle.
- R12: `wake_o` is 1 exactly when at least one flag bit in either register is 1.
- R13: The register map is as follows. Address 0 holds the enables: bit 7 is the mode select, bits 5..0 match the pending bit positions, and bit 6 always reads 0. Address 1 holds the pending flags in bits 5..0. Address 2 holds the cause flags in bits 7..2. Address 3 and all unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_i | input | 1 | Timer expiry pulse, synchronous |
| button_i | input | 1 | Push-button pin, asynchronous |
| rx_i | input | 1 | Serial receive line, asynchronous |
| gpio_a_i | input | 1 | General pin A (transition qualified) |
| gpio_b_i | input | 1 | General pin B (level qualified) |
| gpio_c_i | input | 1 | General pin C (level qualified in mode 1) |
| opt_rx_i | input | 1 | Optical receive line (transition qualified in mode 0) |
| rst_pin_i | input | 1 | External reset indication, asynchronous |
| emu_rst_i | input | 1 | Emulator reset indication, asynchronous |
| sw_rst_i | input | 1 | Software reset pulse, synchronous |
| wdog_i | input | 1 | Watchdog overflow pulse, synchronous |
| cold_i | input | 1 | Cold-start pulse, synchronous |
| low_bat_i | input | 1 | Low-battery pulse, synchronous |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for `addr_i` (combinational) |
| wake_o | output | 1 | Combined wake request |

## Verification
The embedded assertions check the following on every cycle:
- The timer and receive flags rise only when their enable bit was set the cycle before.
- A pending flag falls only after a clear write or a cold start.
- A cold start always leaves cause bit 7 set.
- A level qualifier reaches its held state only from its final count on a high sample, and returns to idle whenever it sees a low sample while counting.
- A transition event never lasts more than one cycle.

Only the bench scenarios can show the timing-dependent behaviour:
- a 64 ms level sets its flag while a shorter or interrupted level does not;
- a glitch shorter than a fast tick is ignored;
- the mode bit switches the bit-0 source;
- a level-qualified flag resists clearing while its pin stays high.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

    typedef enum logic [1:0] {
        LQ_IDLE  = 2'd0,
        LQ_COUNT = 2'd1,
        LQ_HELD  = 2'd2
    } lq_state_t;

    typedef enum logic {
        EQ_STABLE = 1'b0,
        EQ_SETTLE = 1'b1
    } eq_state_t;

    // register addresses
    localparam logic [1:0] ADDR_EN  = 2'd0;
    localparam logic [1:0] ADDR_PND = 2'd1;
    localparam logic [1:0] ADDR_CSE = 2'd2;

    // pending-flag bit positions
    localparam int PB_TMR = 5;
    localparam int PB_RX  = 4;
    localparam int PB_BTN = 3;
    localparam int PB_GA  = 2;
    localparam int PB_GB  = 1;
    localparam int PB_GC  = 0;

    // enable-register mode bit
    localparam int EN_MODE = 7;
    localparam logic [7:0] EN_WMASK = 8'hBF;
    localparam logic [7:0] CSE_MASK = 8'hFC;

    // synchronized pin vector positions
    localparam int NPIN  = 8;
    localparam int S_BTN = 0;
    localparam int S_RX  = 1;
    localparam int S_GA  = 2;
    localparam int S_GB  = 3;
    localparam int S_GC  = 4;
    localparam int S_OPT = 5;
    localparam int S_RST = 6;
    localparam int S_EMU = 7;

endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/wkup_tick_gen.sv
module wkup_tick_gen #(
    parameter int FAST_DIV = 100,
    parameter int SLOW_DIV = 2000
) (
    input  logic clk,
    input  logic rst_n,
    output logic fast_tick_o,
    output logic slow_tick_o
);
    localparam int FW = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
    localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [FW-1:0] F_LAST = FW'(FAST_DIV - 1);
    localparam logic [SW-1:0] S_LAST = SW'(SLOW_DIV - 1);

    logic [FW-1:0] fcnt_q;
    logic [SW-1:0] scnt_q;
    logic          f_wrap;
    logic          s_wrap;

    always_comb begin
        f_wrap = (fcnt_q == F_LAST);
        s_wrap = f_wrap && (scnt_q == S_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcnt_q <= '0;
            scnt_q <= '0;
        end else begin
            fcnt_q <= f_wrap ? '0 : fcnt_q + 1'b1;
            if (f_wrap) begin
                scnt_q <= s_wrap ? '0 : scnt_q + 1'b1;
            end
        end
    end

    assign fast_tick_o = f_wrap;
    assign slow_tick_o = s_wrap;
endmodule

// File: rtl/wkup_level_qual.sv
module wkup_level_qual
    import wkup_pkg::*;
#(
    parameter int SAMPLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    input  logic pin_i,
    output logic qual_o
);
    localparam int CW = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

    lq_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (sample_i) begin
            unique case (state_q)
                LQ_IDLE: begin
                    if (pin_i) begin
                        state_d = LQ_COUNT;
                        cnt_d   = CW'(1);
                    end
                end
                LQ_COUNT: begin
                    if (!pin_i) begin
                        state_d = LQ_IDLE;
                        cnt_d   = '0;
                    end else if (cnt_q == LAST) begin
                        state_d = LQ_HELD;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                LQ_HELD: begin
                    if (!pin_i) begin
                        state_d = LQ_IDLE;
                    end
                end
                default: begin
                    state_d = LQ_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        qual_o = (state_q == LQ_HELD);
    end

    // R3
    held_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qual_o) |-> $past(sample_i && pin_i && (cnt_q == LAST)));

    // R4
    low_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LQ_COUNT && sample_i && !pin_i) |=> (state_q == LQ_IDLE && cnt_q == '0));
endmodule

// File: rtl/wkup_edge_qual.sv
module wkup_edge_qual
    import wkup_pkg::*;
#(
    parameter int TICKS      = 2,
    parameter bit BOTH_EDGES = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pin_i,
    output logic evt_o
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    eq_state_t     state_q, state_d;
    logic          lvl_q, lvl_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          accept;

    // next-state logic
    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        cnt_d   = cnt_q;
        accept  = 1'b0;
        unique case (state_q)
            EQ_STABLE: begin
                if (pin_i != lvl_q) begin
                    state_d = EQ_SETTLE;
                    cnt_d   = '0;
                end
            end
            EQ_SETTLE: begin
                if (pin_i == lvl_q) begin
                    state_d = EQ_STABLE;
                end else if (tick_i) begin
                    if (cnt_q == LAST) begin
                        accept  = 1'b1;
                        state_d = EQ_STABLE;
                        lvl_d   = pin_i;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = EQ_STABLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EQ_STABLE;
            lvl_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        evt_o = accept && (BOTH_EDGES || pin_i);
    end

    // R6
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o);

    // R6
    glitch_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EQ_SETTLE && pin_i == lvl_q) |=> (state_q == EQ_STABLE && $stable(lvl_q)));
endmodule

// File: rtl/wkup_collector.sv
module wkup_collector
    import wkup_pkg::*;
#(
    parameter int FAST_DIV      = 100,
    parameter int SLOW_DIV      = 2000,
    parameter int EDGE_TICKS    = 2,
    parameter int LEVEL_SAMPLES = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       timer_i,
    input  logic       button_i,
    input  logic       rx_i,
    input  logic       gpio_a_i,
    input  logic       gpio_b_i,
    input  logic       gpio_c_i,
    input  logic       opt_rx_i,
    input  logic       rst_pin_i,
    input  logic       emu_rst_i,
    input  logic       sw_rst_i,
    input  logic       wdog_i,
    input  logic       cold_i,
    input  logic       low_bat_i,
    input  logic [1:0] addr_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] rd_data_o,
    output logic       wake_o
);
    localparam int NLVL = 3;   // button, gpio B, gpio C
    localparam int NEDG = 5;   // rx, gpio A, optical, reset pin, emulator
    localparam int NBOTH = 3;  // first NBOTH transition qualifiers see both edges

    logic [NPIN-1:0] pins_raw, pins_s;
    logic            fast_tick, slow_tick;
    logic [NLVL-1:0] lvl_in, lvl_ok;
    logic [NEDG-1:0] edg_in, edg_evt;

    logic [7:0] en_q;
    logic [5:0] pnd_q, pnd_set, pnd_clr;
    logic [7:0] cse_q, cse_set, cse_clr;
    logic       bit0_src;

    assign pins_raw = {emu_rst_i, rst_pin_i, opt_rx_i, gpio_c_i,
                       gpio_b_i, gpio_a_i, rx_i, button_i};

    wkup_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_raw),
        .q_o   (pins_s)
    );

    wkup_tick_gen #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_ticks (
        .clk         (clk),
        .rst_n       (rst_n),
        .fast_tick_o (fast_tick),
        .slow_tick_o (slow_tick)
    );

    assign lvl_in = {pins_s[S_GC], pins_s[S_GB], pins_s[S_BTN]};
    assign edg_in = {pins_s[S_EMU], pins_s[S_RST], pins_s[S_OPT], pins_s[S_GA], pins_s[S_RX]};

    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        wkup_level_qual #(.SAMPLES(LEVEL_SAMPLES)) u_lq (
            .clk      (clk),
            .rst_n    (rst_n),
            .sample_i (slow_tick),
            .pin_i    (lvl_in[g]),
            .qual_o   (lvl_ok[g])
        );
    end

    for (genvar g = 0; g < NEDG; g++) begin : g_edg
        wkup_edge_qual #(.TICKS(EDGE_TICKS), .BOTH_EDGES(g < NBOTH)) u_eq (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (fast_tick),
            .pin_i  (edg_in[g]),
            .evt_o  (edg_evt[g])
        );
    end

    // set and clear terms
    always_comb begin
        bit0_src         = en_q[EN_MODE] ? lvl_ok[2] : edg_evt[2];
        pnd_set          = '0;
        pnd_set[PB_TMR]  = timer_i    & en_q[PB_TMR];
        pnd_set[PB_RX]   = edg_evt[0] & en_q[PB_RX];
        pnd_set[PB_BTN]  = lvl_ok[0]  & en_q[PB_BTN];
        pnd_set[PB_GA]   = edg_evt[1] & en_q[PB_GA];
        pnd_set[PB_GB]   = lvl_ok[1]  & en_q[PB_GB];
        pnd_set[PB_GC]   = bit0_src   & en_q[PB_GC];
        cse_set          = {cold_i, edg_evt[3], sw_rst_i, wdog_i, edg_evt[4], low_bat_i, 2'b00};
        pnd_clr          = (wr_en_i && addr_i == ADDR_PND) ? wr_data_i[5:0] : 6'd0;
        cse_clr          = (wr_en_i && addr_i == ADDR_CSE) ? (wr_data_i & CSE_MASK) : 8'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            pnd_q <= '0;
            cse_q <= '0;
        end else begin
            if (wr_en_i && addr_i == ADDR_EN) begin
                en_q <= wr_data_i & EN_WMASK;
            end
            pnd_q <= (cold_i ? 6'd0 : (pnd_q & ~pnd_clr)) | pnd_set;
            cse_q <= (cold_i ? 8'd0 : (cse_q & ~cse_clr)) | cse_set;
        end
    end

    always_comb begin
        unique case (addr_i)
            ADDR_EN:  rd_data_o = en_q;
            ADDR_PND: rd_data_o = {2'b00, pnd_q};
            ADDR_CSE: rd_data_o = cse_q;
            default:  rd_data_o = 8'h00;
        endcase
        wake_o = (|pnd_q) | (|cse_q);
    end

    // R2
    timer_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pnd_q[PB_TMR]) |-> $past(timer_i && en_q[PB_TMR]));

    // R9
    rx_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pnd_q[PB_RX]) |-> $past(en_q[PB_RX]));

    // R10
    sticky_pnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(pnd_q) & ~pnd_q)) |-> $past((wr_en_i && addr_i == ADDR_PND) || cold_i));

    // R11
    cold_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cold_i |=> cse_q[7]);
endmodule

// File: tb/wkup_collector_tb_top.sv
module wkup_collector_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic       timer_i, button_i, rx_i, gpio_a_i, gpio_b_i, gpio_c_i, opt_rx_i;
    logic       rst_pin_i, emu_rst_i, sw_rst_i, wdog_i, cold_i, low_bat_i;
    logic [1:0] addr_i;
    logic       wr_en_i;
    logic [7:0] wr_data_i;
    logic [7:0] rd_data_o;
    logic       wake_o;

    localparam int LONG  = 640;  // 40 slow ticks of 16 cycles
    localparam int SHORT = 320;  // 20 slow ticks
    localparam int EDGE  = 40;   // ten fast ticks

    wkup_collector #(.FAST_DIV(4), .SLOW_DIV(4), .EDGE_TICKS(2), .LEVEL_SAMPLES(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .timer_i(timer_i), .button_i(button_i), .rx_i(rx_i),
        .gpio_a_i(gpio_a_i), .gpio_b_i(gpio_b_i), .gpio_c_i(gpio_c_i), .opt_rx_i(opt_rx_i),
        .rst_pin_i(rst_pin_i), .emu_rst_i(emu_rst_i), .sw_rst_i(sw_rst_i), .wdog_i(wdog_i),
        .cold_i(cold_i), .low_bat_i(low_bat_i), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .wake_o(wake_o)
    );

    typedef struct packed {
        logic [1:0] a;
        logic [7:0] d;
        logic       w;
        logic       uw;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_fail = 0;

    // monitor: compares one expected item per cycle
    exp_t  cur;
    string cur_tag;
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            cur     = exp_q.pop_front();
            cur_tag = tag_q.pop_front();
            n_chk++;
            if (rd_data_o !== cur.d) begin
                n_fail++;
                $display("FAIL %s addr=%0d: actual=%02h expected=%02h", cur_tag, cur.a, rd_data_o, cur.d);
            end
            if (cur.uw) begin
                n_chk++;
                if (wake_o !== cur.w) begin
                    n_fail++;
                    $display("FAIL %s wake: actual=%b expected=%b", cur_tag, wake_o, cur.w);
                end
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic expect_rd(input logic [1:0] a, input logic [7:0] d, input string t);
        @(posedge clk); #1;
        addr_i = a;
        exp_q.push_back('{a: a, d: d, w: 1'b0, uw: 1'b0});
        tag_q.push_back(t);
    endtask

    task automatic expect_rdw(input logic [1:0] a, input logic [7:0] d, input logic w, input string t);
        @(posedge clk); #1;
        addr_i = a;
        exp_q.push_back('{a: a, d: d, w: w, uw: 1'b1});
        tag_q.push_back(t);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
        @(posedge clk); #1;
        wr_en_i = 1'b0;
    endtask

    // 0 timer, 1 sw reset, 2 watchdog, 3 low battery, 4 cold start
    task automatic pulse_sync(input int which);
        @(posedge clk); #1;
        case (which)
            0: timer_i = 1'b1;
            1: sw_rst_i = 1'b1;
            2: wdog_i = 1'b1;
            3: low_bat_i = 1'b1;
            default: cold_i = 1'b1;
        endcase
        @(posedge clk); #1;
        timer_i = 1'b0; sw_rst_i = 1'b0; wdog_i = 1'b0; low_bat_i = 1'b0; cold_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        wait_cyc(100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (R1..R13 run): actual=hung expected=complete");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        timer_i = 0; button_i = 0; rx_i = 1; gpio_a_i = 0; gpio_b_i = 0; gpio_c_i = 0;
        opt_rx_i = 1; rst_pin_i = 0; emu_rst_i = 0; sw_rst_i = 0; wdog_i = 0; cold_i = 0;
        low_bat_i = 0; addr_i = 0; wr_en_i = 0; wr_data_i = 0;
        wait_cyc(4); #1;
        rst_n = 1'b1;
        wait_cyc(60);

        // R1 reset state
        expect_rdw(2'd0, 8'h00, 1'b0, "R1 enables");
        expect_rdw(2'd1, 8'h00, 1'b0, "R1 pending");
        expect_rdw(2'd2, 8'h00, 1'b0, "R1 causes");

        // R13 register map
        reg_wr(2'd0, 8'hFF);
        expect_rd(2'd0, 8'hBF, "R13 enable readback");
        expect_rd(2'd3, 8'h00, "R13 unused address");
        reg_wr(2'd0, 8'h00);

        // R2 timer gated by arm bit
        pulse_sync(0);
        expect_rdw(2'd1, 8'h00, 1'b0, "R2 timer unarmed");
        reg_wr(2'd0, 8'h20);
        pulse_sync(0);
        expect_rdw(2'd1, 8'h20, 1'b1, "R2/R12 timer armed");

        // R10 write-one-to-clear, zeros untouched, set beats clear
        reg_wr(2'd1, 8'h1F);
        expect_rd(2'd1, 8'h20, "R10 zero bits untouched");
        reg_wr(2'd1, 8'h20);
        expect_rdw(2'd1, 8'h00, 1'b0, "R10/R12 cleared");
        @(posedge clk); #1;
        timer_i = 1'b1; addr_i = 2'd1; wr_data_i = 8'h20; wr_en_i = 1'b1;
        @(posedge clk); #1;
        timer_i = 1'b0; wr_en_i = 1'b0;
        expect_rd(2'd1, 8'h20, "R5 set wins over clear");
        reg_wr(2'd1, 8'h20);

        // R3 button level qualifier
        reg_wr(2'd0, 8'h0A);
        button_i = 1'b1;
        wait_cyc(SHORT);
        button_i = 1'b0;
        wait_cyc(60);
        expect_rd(2'd1, 8'h00, "R3 short high ignored");
        // R4 restart after a low sample
        button_i = 1'b1; wait_cyc(25 * 16);
        button_i = 1'b0; wait_cyc(48);
        button_i = 1'b1; wait_cyc(25 * 16);
        button_i = 1'b0; wait_cyc(60);
        expect_rd(2'd1, 8'h00, "R4 interrupted high ignored");
        button_i = 1'b1;
        wait_cyc(LONG);
        expect_rd(2'd1, 8'h08, "R3 button qualified");
        // R5 level-sensitive: clear blocked while high
        reg_wr(2'd1, 8'h08);
        expect_rd(2'd1, 8'h08, "R5 clear blocked while high");
        button_i = 1'b0;
        wait_cyc(60);
        reg_wr(2'd1, 8'h08);
        expect_rd(2'd1, 8'h00, "R5 clear after low");
        // R3 gpio B level
        gpio_b_i = 1'b1;
        wait_cyc(LONG);
        expect_rd(2'd1, 8'h02, "R3 gpio B qualified");
        gpio_b_i = 1'b0;
        wait_cyc(60);
        reg_wr(2'd1, 8'h02);

        // R6 receive line, both edges
        reg_wr(2'd0, 8'h14);
        rx_i = 1'b0; wait_cyc(EDGE);
        expect_rd(2'd1, 8'h10, "R6 rx falling edge");
        reg_wr(2'd1, 8'h10);
        rx_i = 1'b1; wait_cyc(EDGE);
        expect_rd(2'd1, 8'h10, "R6 rx rising edge");
        reg_wr(2'd1, 8'h10);
        rx_i = 1'b0; wait_cyc(3); rx_i = 1'b1; wait_cyc(EDGE);
        expect_rd(2'd1, 8'h00, "R6 rx glitch ignored");
        gpio_a_i = 1'b1; wait_cyc(EDGE);
        expect_rd(2'd1, 8'h04, "R6 gpio A rising");
        reg_wr(2'd1, 8'h04);
        gpio_a_i = 1'b0; wait_cyc(EDGE);
        expect_rd(2'd1, 8'h04, "R6 gpio A falling");
        reg_wr(2'd1, 8'h04);

        // R9 event while disabled is lost
        reg_wr(2'd0, 8'h00);
        rx_i = 1'b0; wait_cyc(EDGE);
        rx_i = 1'b1; wait_cyc(EDGE);
        reg_wr(2'd0, 8'h10);
        wait_cyc(4);
        expect_rdw(2'd1, 8'h00, 1'b0, "R9 disabled event lost");

        // R7 bit-0 source select
        reg_wr(2'd0, 8'h01);
        gpio_c_i = 1'b1; wait_cyc(LONG);
        expect_rd(2'd1, 8'h00, "R7 mode0 gpio C ignored");
        opt_rx_i = 1'b0; wait_cyc(EDGE);
        expect_rd(2'd1, 8'h01, "R7 mode0 optical edge");
        gpio_c_i = 1'b0; wait_cyc(60);
        reg_wr(2'd1, 8'h01);
        reg_wr(2'd0, 8'h81);
        opt_rx_i = 1'b1; wait_cyc(EDGE);
        expect_rd(2'd1, 8'h00, "R7 mode1 optical ignored");
        gpio_c_i = 1'b1; wait_cyc(LONG);
        expect_rd(2'd1, 8'h01, "R7 mode1 gpio C level");
        gpio_c_i = 1'b0; wait_cyc(60);
        reg_wr(2'd1, 8'h01);
        reg_wr(2'd0, 8'h00);

        // R8 reset causes, always enabled
        pulse_sync(1);
        expect_rdw(2'd2, 8'h20, 1'b1, "R8 sw reset cause");
        pulse_sync(2);
        pulse_sync(3);
        expect_rd(2'd2, 8'h34, "R8 watchdog and low battery");
        rst_pin_i = 1'b1; wait_cyc(EDGE); rst_pin_i = 1'b0; wait_cyc(EDGE);
        expect_rd(2'd2, 8'h74, "R8 reset pin");
        emu_rst_i = 1'b1; wait_cyc(3); emu_rst_i = 1'b0; wait_cyc(EDGE);
        expect_rd(2'd2, 8'h74, "R8 emulator glitch ignored");
        emu_rst_i = 1'b1; wait_cyc(EDGE); emu_rst_i = 1'b0; wait_cyc(EDGE);
        expect_rd(2'd2, 8'h7C, "R8 emulator reset");
        reg_wr(2'd2, 8'hFC);
        expect_rdw(2'd2, 8'h00, 1'b0, "R10/R12 causes cleared");

        // R11 cold start
        reg_wr(2'd0, 8'h20);
        pulse_sync(0);
        pulse_sync(2);
        pulse_sync(4);
        expect_rdw(2'd1, 8'h00, 1'b1, "R11 pending cleared by cold");
        expect_rd(2'd2, 8'h80, "R11 cold cause only");
        reg_wr(2'd2, 8'h80);
        expect_rdw(2'd2, 8'h00, 1'b0, "R12 all clear");

        wait (exp_q.size() == 0);
        wait_cyc(2);
        finish_run();
    end
endmodule